// File: doc/BRIEF.md
# GPIO Pin Register Bank

This block holds the configuration and data state for a bank of eighteen general-purpose pins and presents it through a byte-wide synchronous register port. Software sets each pin's direction, changes output levels through separate write-one-to-set and write-one-to-clear locations, selects a pull-up or pull-down per pin, flags pins for debounce, and reads back the synchronized pin levels. A global control byte switches the whole pin module on and carries two card-detect enables that apply to pins 0 and 1 only.

The pad side sees per-pin output values, output enables, pull selects and debounce enables. Pin inputs cross into the clock domain through a two-flop synchronizer. While the module is off, all output enables are forced inactive and the input data register holds its last value, while every stored register keeps its contents.

Per-pin registers pack eight pins to a byte (pin n at byte offset n/8, bit n%8). Pull control packs four pins to a byte, two bits per pin.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register is zero: all outputs low, no output enabled, no pull selected, module off, and every address reads 0.
- R2: The direction bytes at addresses 1..3 hold pin n at address 1+n/8, bit n%8; a 1 makes the pin an output, and pin_oe_o equals the direction bits while the module is on.
- R3: A write to the set bytes at 10..12 sets each output bit whose written bit is 1 and leaves the rest unchanged; the output bytes read back at 7..9 with the same layout, and pin_out_o follows them.
- R4: A write to the clear bytes at 13..15 clears each output bit whose written bit is 1 and leaves the rest unchanged.
- R5: The set and clear bytes read as 0, and writes to the output bytes (7..9) or input bytes (4..6) change nothing.
- R6: Pin levels pass a two-flop synchronizer and then the input register, read at 4..6 with the direction layout; a pin change is in the input register three clock edges after it is applied.
- R7: Pull bytes at 16..20 hold four pins each: for pin 4b+k in byte 16+b, bit 2k selects pull-down and bit 2k+1 selects pull-up.
- R8: When both pull bits of a pin are 1, neither pin_pu_o nor pin_pd_o is asserted for that pin; the stored bits still read back.
- R9: The control byte at address 0 has bit 2 as module-on (module_on_o) and bits 0 and 1 as the card-detect enables for pins 0 and 1 (cd_en_o); bits 3..7 read 0.
- R10: While module-on is 0, pin_oe_o is all zero and the input register holds its value; direction, output, pull and debounce contents are kept and reappear when the module is switched on.
- R11: Debounce-enable bytes at 21..23 use the direction layout and drive deb_en_o.
- R12: Bit positions above pin 17 in any byte and the addresses 24..31 read 0, and writes to them have no effect.
- R13: Read data appears on rdata_o after the clock edge that samples re_i, and rdata_o holds its value in cycles without re_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, applied at the next clock edge |
| re_i | input | 1 | Read strobe, data returned after the next clock edge |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 18 | Pin input levels, asynchronous |
| pin_out_o | output | 18 | Pin output values |
| pin_oe_o | output | 18 | Pin output enables |
| pin_pu_o | output | 18 | Pull-up selects |
| pin_pd_o | output | 18 | Pull-down selects |
| deb_en_o | output | 18 | Debounce enables |
| cd_en_o | output | 2 | Card-detect enables for pins 0 and 1 |
| module_on_o | output | 1 | Pin module enable |

## Verification
A write takes effect at the clock edge that samples we_i, so the pad outputs are checked at the falling edge right after that edge, and a read returns on rdata_o one edge after re_i. A pin change needs three edges to reach the input register plus the read edge, so the bench waits two falling edges after a change and expects the old value, then reads again and expects the new one. Switching the module on lets the input register load at the edge after the control write, and the bench waits past it before reading.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam int BYTE_W      = 8;
  localparam int PULL_PINS_B = 4;
  localparam int CTRL_W      = 3;
  localparam int CTRL_ON     = 2;
  localparam int CD_PINS     = 2;

  typedef enum int {
    REG_CTRL = 0, REG_DIR, REG_DIN, REG_DOUT, REG_SET, REG_CLR,
    REG_PULL, REG_DEB, REG_END
  } gpio_reg_e;

  function automatic int data_bytes(int n);
    return (n + BYTE_W - 1) / BYTE_W;
  endfunction

  function automatic int pull_bytes(int n);
    return (n + PULL_PINS_B - 1) / PULL_PINS_B;
  endfunction

  function automatic int reg_size(int n, gpio_reg_e r);
    case (r)
      REG_CTRL: return 1;
      REG_PULL: return pull_bytes(n);
      REG_END:  return 0;
      default:  return data_bytes(n);
    endcase
  endfunction

  function automatic int reg_base(int n, gpio_reg_e r);
    int b;
    b = 0;
    for (int i = 0; i < int'(r); i++) b += reg_size(n, gpio_reg_e'(i));
    return b;
  endfunction

  function automatic int addr_w(int n);
    return $clog2(reg_base(n, REG_END));
  endfunction

endpackage

// File: rtl/gpio_bit_reg.sv
module gpio_bit_reg #(
  parameter int N        = 18,
  parameter int ADDR_W   = 5,
  parameter int BASE     = 1,
  parameter int BASE_CLR = 0,
  parameter bit SET_CLR  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [N-1:0]      q_o
);

  logic [N-1:0] q_q, q_d;
  int addr_n;
  assign addr_n = int'(addr_i);

  for (genvar n = 0; n < N; n++) begin : g_bit
    localparam int BYTE_IDX = n / 8;
    localparam int BIT_IDX  = n % 8;
    logic hit;
    assign hit = we_i && (addr_n == BASE + BYTE_IDX);
    if (SET_CLR) begin : g_sc
      logic hit_c;
      assign hit_c = we_i && (addr_n == BASE_CLR + BYTE_IDX);
      // set and clear locations never share an address
      assign q_d[n] = hit   ? (q_q[n] | wdata_i[BIT_IDX])
                    : hit_c ? (q_q[n] & ~wdata_i[BIT_IDX])
                    : q_q[n];
    end else begin : g_plain
      assign q_d[n] = hit ? wdata_i[BIT_IDX] : q_q[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] din_o
);

  logic [N-1:0] s1_q, s2_q, din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      din_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (en_i) din_q <= s2_q;
    end
  end

  assign din_o = din_q;

endmodule

// File: rtl/gpio_pull_map.sv
module gpio_pull_map #(
  parameter int N = 18
) (
  input  logic [2*N-1:0] raw_i,
  output logic [N-1:0]   pu_o,
  output logic [N-1:0]   pd_o
);

  for (genvar n = 0; n < N; n++) begin : g_pin
    // conflicting request drives neither pull
    assign pd_o[n] = raw_i[2*n]   & ~raw_i[2*n+1];
    assign pu_o[n] = raw_i[2*n+1] & ~raw_i[2*n];
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int ADDR_W   = addr_w(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_pu_o,
  output logic [NUM_PINS-1:0] pin_pd_o,
  output logic [NUM_PINS-1:0] deb_en_o,
  output logic [CD_PINS-1:0]  cd_en_o,
  output logic                module_on_o
);

  localparam int DB     = data_bytes(NUM_PINS);
  localparam int PB     = pull_bytes(NUM_PINS);
  localparam int A_CTRL = reg_base(NUM_PINS, REG_CTRL);
  localparam int A_DIR  = reg_base(NUM_PINS, REG_DIR);
  localparam int A_DIN  = reg_base(NUM_PINS, REG_DIN);
  localparam int A_DOUT = reg_base(NUM_PINS, REG_DOUT);
  localparam int A_SET  = reg_base(NUM_PINS, REG_SET);
  localparam int A_CLR  = reg_base(NUM_PINS, REG_CLR);
  localparam int A_PULL = reg_base(NUM_PINS, REG_PULL);
  localparam int A_DEB  = reg_base(NUM_PINS, REG_DEB);

  int addr_n;
  assign addr_n = int'(addr_i);

  logic [CTRL_W-1:0]     ctrl_q;
  logic                  module_on;
  logic [NUM_PINS-1:0]   dir_q, dout_q, deb_q, din_q;
  logic [2*NUM_PINS-1:0] pull_q;
  logic [7:0]            rd_nxt, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= '0;
    else if (we_i && addr_n == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign module_on = ctrl_q[CTRL_ON];

  gpio_bit_reg #(.N(NUM_PINS), .ADDR_W(ADDR_W), .BASE(A_DIR),
                 .BASE_CLR(0), .SET_CLR(1'b0)) u_dir (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(dir_q)
  );

  gpio_bit_reg #(.N(NUM_PINS), .ADDR_W(ADDR_W), .BASE(A_SET),
                 .BASE_CLR(A_CLR), .SET_CLR(1'b1)) u_dout (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(dout_q)
  );

  gpio_bit_reg #(.N(2*NUM_PINS), .ADDR_W(ADDR_W), .BASE(A_PULL),
                 .BASE_CLR(0), .SET_CLR(1'b0)) u_pull (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(pull_q)
  );

  gpio_bit_reg #(.N(NUM_PINS), .ADDR_W(ADDR_W), .BASE(A_DEB),
                 .BASE_CLR(0), .SET_CLR(1'b0)) u_deb (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(deb_q)
  );

  gpio_in_sync #(.N(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .en_i(module_on), .pin_i, .din_o(din_q)
  );

  gpio_pull_map #(.N(NUM_PINS)) u_pmap (
    .raw_i(pull_q), .pu_o(pin_pu_o), .pd_o(pin_pd_o)
  );

  // read path: byte-padded views, unused bit positions read 0
  logic [DB*8-1:0] dir_pad, din_pad, dout_pad, deb_pad;
  logic [PB*8-1:0] pull_pad;

  assign dir_pad  = (DB*8)'(dir_q);
  assign din_pad  = (DB*8)'(din_q);
  assign dout_pad = (DB*8)'(dout_q);
  assign deb_pad  = (DB*8)'(deb_q);
  assign pull_pad = (PB*8)'(pull_q);

  always_comb begin
    rd_nxt = '0;
    if (addr_n == A_CTRL) rd_nxt = 8'(ctrl_q);
    for (int b = 0; b < DB; b++) begin
      if (addr_n == A_DIR + b)  rd_nxt = dir_pad[b*8 +: 8];
      if (addr_n == A_DIN + b)  rd_nxt = din_pad[b*8 +: 8];
      if (addr_n == A_DOUT + b) rd_nxt = dout_pad[b*8 +: 8];
      if (addr_n == A_DEB + b)  rd_nxt = deb_pad[b*8 +: 8];
    end
    for (int b = 0; b < PB; b++) begin
      if (addr_n == A_PULL + b) rd_nxt = pull_pad[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_nxt;
  end

  assign rdata_o     = rdata_q;
  assign pin_out_o   = dout_q;
  assign pin_oe_o    = dir_q & {NUM_PINS{module_on}};
  assign deb_en_o    = deb_q;
  assign cd_en_o     = ctrl_q[CD_PINS-1:0];
  assign module_on_o = module_on;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int ADDR_W   = addr_w(NUM_PINS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic                re_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [7:0]          rdata_o,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] pin_pu_o,
  input logic [NUM_PINS-1:0] pin_pd_o,
  input logic                module_on_o,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] din_q
);

  localparam int DB    = data_bytes(NUM_PINS);
  localparam int A_DIR = reg_base(NUM_PINS, REG_DIR);
  localparam int A_SET = reg_base(NUM_PINS, REG_SET);
  localparam int A_CLR = reg_base(NUM_PINS, REG_CLR);

  int addr_n;
  logic wr_dir, wr_set, wr_clr;
  assign addr_n = int'(addr_i);
  assign wr_dir = we_i && addr_n >= A_DIR && addr_n < A_DIR + DB;
  assign wr_set = we_i && addr_n >= A_SET && addr_n < A_SET + DB;
  assign wr_clr = we_i && addr_n >= A_CLR && addr_n < A_CLR + DB;

  // R10
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !module_on_o |-> pin_oe_o == '0);

  // R10
  din_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !module_on_o |=> $stable(din_q));

  // R8
  pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pu_o & pin_pd_o) == '0);

  // R3
  set_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ($past(pin_out_o) & ~pin_out_o) == '0);

  // R4
  clr_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (pin_out_o & ~$past(pin_out_o)) == '0);

  // R5
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(pin_out_o));

  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir |=> $stable(dir_q));

  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

endmodule

bind gpio_regbank gpio_regbank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o),
  .pin_pu_o(pin_pu_o), .pin_pd_o(pin_pd_o), .module_on_o(module_on_o),
  .dir_q(dir_q), .din_q(din_q)
);

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [17:0] pin_i = '0;
  logic [17:0] pin_out_o, pin_oe_o, pin_pu_o, pin_pd_o, deb_en_o;
  logic [1:0]  cd_en_o;
  logic        module_on_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_regbank u0 (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o, .pin_i,
    .pin_out_o, .pin_oe_o, .pin_pu_o, .pin_pd_o, .deb_en_o, .cd_en_o,
    .module_on_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    addr_i = 5'(a); wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr_i = 5'(a); re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 out", 32'(pin_out_o), 0);
    chk("R1 oe", 32'(pin_oe_o), 0);
    chk("R1 pu|pd", 32'(pin_pu_o | pin_pd_o), 0);
    chk("R1 on", 32'(module_on_o), 0);
    for (int a = 0; a < 24; a++) begin
      rd(a, d);
      chk($sformatf("R1 read %0d", a), 32'(d), 0);
    end
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(0, 8'hFF);
    chk("R9 on", 32'(module_on_o), 1);
    chk("R9 cd", 32'(cd_en_o), 3);
    rd(0, d);
    chk("R9 ctrl upper bits", 32'(d), 32'h07);
    wr(0, 8'h04);
    chk("R9 cd off", 32'(cd_en_o), 0);
    chk("R9 still on", 32'(module_on_o), 1);
  endtask

  task automatic t_dir;
    logic [7:0] d;
    wr(1, 8'hA5); wr(2, 8'h3C); wr(3, 8'hFF);
    chk("R2 oe", 32'(pin_oe_o), 32'h33CA5);
    rd(2, d);
    chk("R2 dir byte1", 32'(d), 32'h3C);
    rd(3, d);
    chk("R12 dir byte2 unused bits", 32'(d), 32'h03);
  endtask

  task automatic t_setclr;
    logic [7:0] d;
    wr(10, 8'h0F);
    chk("R3 set byte0", 32'(pin_out_o), 32'h0000F);
    wr(11, 8'h81);
    chk("R3 set byte1", 32'(pin_out_o), 32'h0810F);
    wr(13, 8'h05);
    chk("R4 clr byte0", 32'(pin_out_o), 32'h0810A);
    wr(10, 8'h00);
    chk("R3 set zero", 32'(pin_out_o), 32'h0810A);
    wr(14, 8'h01);
    chk("R4 clr byte1", 32'(pin_out_o), 32'h0800A);
    wr(12, 8'hFF);
    chk("R3 set byte2", 32'(pin_out_o), 32'h3800A);
    rd(9, d);
    chk("R3 dout byte2", 32'(d), 32'h03);
    rd(7, d);
    chk("R3 dout byte0", 32'(d), 32'h0A);
    rd(10, d);
    chk("R5 set reads 0", 32'(d), 0);
    rd(13, d);
    chk("R5 clr reads 0", 32'(d), 0);
    wr(7, 8'hFF);
    chk("R5 dout write ignored", 32'(pin_out_o), 32'h3800A);
  endtask

  task automatic t_input;
    logic [7:0] d;
    pin_i = 18'h25A3C;
    repeat (3) @(negedge clk_i);
    rd(4, d); chk("R6 din byte0", 32'(d), 32'h3C);
    rd(5, d); chk("R6 din byte1", 32'(d), 32'h5A);
    rd(6, d); chk("R6 din byte2", 32'(d), 32'h02);
    pin_i = 18'h25AC3;
    repeat (2) @(negedge clk_i);
    rd(4, d); chk("R6 latency old", 32'(d), 32'h3C);
    rd(4, d); chk("R6 latency new", 32'(d), 32'hC3);
    wr(4, 8'h00);
    rd(4, d); chk("R5 din write ignored", 32'(d), 32'hC3);
  endtask

  task automatic t_pull;
    logic [7:0] d;
    wr(16, 8'h06);
    chk("R7 pu pin0", 32'(pin_pu_o), 32'h00001);
    chk("R7 pd pin1", 32'(pin_pd_o), 32'h00002);
    wr(20, 8'hF9);
    chk("R7 pu pin17", 32'(pin_pu_o), 32'h20001);
    chk("R7 pd pin16", 32'(pin_pd_o), 32'h10002);
    rd(20, d);
    chk("R12 pull byte4 unused", 32'(d), 32'h09);
    wr(18, 8'h03);
    chk("R8 both pu", 32'(pin_pu_o), 32'h20001);
    chk("R8 both pd", 32'(pin_pd_o), 32'h10002);
    rd(18, d);
    chk("R8 readback", 32'(d), 32'h03);
  endtask

  task automatic t_deb;
    logic [7:0] d;
    wr(21, 8'h80); wr(23, 8'h02);
    chk("R11 deb", 32'(deb_en_o), 32'h20080);
    rd(23, d);
    chk("R11 deb byte2", 32'(d), 32'h02);
  endtask

  task automatic t_off;
    logic [7:0] d;
    wr(0, 8'h00);
    chk("R10 oe off", 32'(pin_oe_o), 0);
    chk("R10 out kept", 32'(pin_out_o), 32'h3800A);
    chk("R10 pull kept", 32'(pin_pu_o), 32'h20001);
    pin_i = '0;
    repeat (4) @(negedge clk_i);
    rd(4, d); chk("R10 din held", 32'(d), 32'hC3);
    rd(1, d); chk("R10 dir kept", 32'(d), 32'hA5);
    wr(0, 8'h04);
    chk("R10 oe back", 32'(pin_oe_o), 32'h33CA5);
    repeat (2) @(negedge clk_i);
    rd(4, d); chk("R10 din resumes", 32'(d), 32'h00);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(24, 8'hFF); wr(31, 8'hFF);
    rd(24, d); chk("R12 addr24", 32'(d), 0);
    rd(31, d); chk("R12 addr31", 32'(d), 0);
    chk("R12 out unchanged", 32'(pin_out_o), 32'h3800A);
    chk("R12 oe unchanged", 32'(pin_oe_o), 32'h33CA5);
  endtask

  task automatic t_rdhold;
    logic [7:0] d;
    rd(2, d);
    chk("R13 read", 32'(d), 32'h3C);
    wr(2, 8'h11);
    chk("R13 hold after write", 32'(rdata_o), 32'h3C);
    repeat (3) @(negedge clk_i);
    chk("R13 hold idle", 32'(rdata_o), 32'h3C);
    rd(2, d);
    chk("R13 new read", 32'(d), 32'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ctrl();
    t_dir();
    t_setclr();
    t_input();
    t_pull();
    t_deb();
    t_off();
    t_unmapped();
    t_rdhold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule